// File: doc/BRIEF.md
# Retention-Binned Row Refresh Controller

This block keeps the rows of one DRAM bank alive without refreshing every row at the worst-case rate. Rows whose cells leak fastest are refreshed on every pass of the row space. Rows that hold their charge longer are refreshed on every second pass or every fourth pass. Which group a row belongs to comes from two small Bloom filters that software fills during a profiling phase. A false positive in a filter can only move a row into a faster group, so a row may get extra refreshes but never too few.

A row pointer steps forward by one row on each base refresh tick. On each tick the controller looks up the current row in the weak filter first and then in the medium filter. The first filter that matches sets the row's refresh rate, and a 2-bit pass counter then decides whether the row is due in this pass. A row that is due raises a request. The request is held until the command scheduler signals that it is idle. The controller then issues one refresh command and keeps the bank marked busy for a fixed number of cycles.

Top module: `rr_refresh_ctrl`

## Requirements
- R1: After reset, ref_req_o, ref_cmd_o and busy_o are 0, ref_row_o is 0, the row pointer is at row 0, the pass counter is 0, and both filters are empty.
- R2: Each cycle with tick_i high moves the row pointer from r to r+1. From row ROWS-1 it goes back to row 0 and the 2-bit pass counter goes up by one, wrapping from 3 to 0.
- R3: A profiling write (prof_we_i, filter prof_bin_i, where 0 is weak and 1 is medium) sets NUM_HASH bits of that filter. Hash k of row r is computed as follows: rotate r left by k positions within ROW_W bits; XOR together the consecutive log2(FILT_BITS)-bit slices of the result, zero-padding the top slice; then XOR in k. A row counts as a member only when all NUM_HASH of its bits are set.
- R4: The weak filter has priority over the medium filter. A row that matches neither is in the strong bin.
- R5: A weak-bin row is due in every pass. A medium-bin row is due when the pass counter is even. A strong-bin row is due only when the pass counter is 0. In the cycle after a tick on a due row, ref_req_o is 1 and ref_row_o holds that row.
- R6: ref_req_o and ref_row_o stay unchanged while sched_idle_i is low.
- R7: In the cycle after a cycle where ref_req_o and sched_idle_i are both high, ref_req_o drops and ref_cmd_o pulses for one cycle. busy_o then stays high for exactly BUSY_CYC consecutive cycles.
- R8: clear_i empties both filters. If clear_i and a profiling write arrive in the same cycle, the clear wins.
- R9: A tick on a row that is not due raises neither ref_req_o nor busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base refresh tick; steps the row pointer |
| clear_i | input | 1 | Empties both filters |
| prof_we_i | input | 1 | Profiling insert strobe |
| prof_bin_i | input | 1 | Target filter: 0 weak, 1 medium |
| prof_row_i | input | ROW_W | Row to insert |
| sched_idle_i | input | 1 | Scheduler grants the bank for a refresh |
| ref_req_o | output | 1 | Refresh pending |
| ref_row_o | output | ROW_W | Row of the pending or current refresh |
| ref_cmd_o | output | 1 | One-cycle refresh command |
| busy_o | output | 1 | Bank unavailable to normal requests |

## Verification
The assertions assume that tick_i arrives only while the controller is idle, that is, with no request pending and the bank not busy. In use, a base tick is far slower than one refresh, so this holds. The bench keeps to this assumption: it raises the next tick only after it has seen busy_o fall, or after it has seen that no request was raised. On some rows the bench holds sched_idle_i low for a few cycles before granting the refresh, which exercises the wait in R6. Profiling writes and clears are issued only between ticks.

// File: rtl/rr_refresh_pkg.sv
package rr_refresh_pkg;
  localparam int unsigned NUM_FILT = 2;
  localparam int unsigned PER_W    = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_BUSY = 2'd2
  } rf_state_e;

  typedef enum logic [1:0] {
    BIN_WEAK   = 2'd0,
    BIN_MID    = 2'd1,
    BIN_STRONG = 2'd2
  } rf_bin_e;

  function automatic logic due_f(input rf_bin_e b, input logic [PER_W-1:0] p);
    case (b)
      BIN_WEAK: return 1'b1;
      BIN_MID:  return ~p[0];
      default:  return (p == '0);
    endcase
  endfunction
endpackage

// File: rtl/rr_bloom_filter.sv
module rr_bloom_filter #(
  parameter int unsigned ROW_W     = 6,
  parameter int unsigned FILT_BITS = 32,
  parameter int unsigned NUM_HASH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic             hit_o
);
  localparam int unsigned IDX_W = $clog2(FILT_BITS);

  logic [FILT_BITS-1:0] bits_q, bits_d;

  // rotate left by k, fold IDX_W-bit slices, salt with k
  function automatic logic [IDX_W-1:0] hash_f(input logic [ROW_W-1:0] r, input int k);
    logic [ROW_W-1:0] v;
    logic [IDX_W-1:0] h;
    v = r;
    for (int s = 0; s < int'(ROW_W); s++)
      if (s < (k % int'(ROW_W))) v = {v[ROW_W-2:0], v[ROW_W-1]};
    h = IDX_W'(k);
    for (int c = 0; c < int'(ROW_W); c += int'(IDX_W)) h = h ^ IDX_W'(v >> c);
    return h;
  endfunction

  always_comb begin
    bits_d = bits_q;
    if (clear_i) bits_d = '0;
    else if (we_i)
      for (int k = 0; k < int'(NUM_HASH); k++) bits_d[hash_f(wr_row_i, k)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  always_comb begin
    hit_o = 1'b1;
    for (int k = 0; k < int'(NUM_HASH); k++) hit_o = hit_o & bits_q[hash_f(rd_row_i, k)];
  end

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !hit_o);

  assert_insert_hits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clear_i) |=> (rd_row_i != $past(wr_row_i) || hit_o));
endmodule

// File: rtl/rr_row_sequencer.sv
module rr_row_sequencer
  import rr_refresh_pkg::*;
#(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [ROW_W-1:0] row_o,
  output logic [PER_W-1:0] per_o
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      per_q <= '0;
    end else if (tick_i) begin
      if (row_q == LAST) begin
        row_q <= '0;
        per_q <= per_q + PER_W'(1);
      end else begin
        row_q <= row_q + ROW_W'(1);
      end
    end
  end

  assign row_o = row_q;
  assign per_o = per_q;

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && row_q == LAST) |=> (row_q == '0 && per_q == $past(per_q) + PER_W'(1)));

  assert_row_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, row_q} < (ROW_W+1)'(ROWS));
endmodule

// File: rtl/rr_refresh_fsm.sv
module rr_refresh_fsm
  import rr_refresh_pkg::*;
#(
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             need_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             sched_idle_i,
  output logic             req_o,
  output logic [ROW_W-1:0] row_o,
  output logic             cmd_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  rf_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      cmd_q   <= 1'b0;
    end else begin
      cmd_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (tick_i && need_i) begin
          state_q <= ST_PEND;
          row_q   <= row_i;
        end
        ST_PEND: if (sched_idle_i) begin
          state_q <= ST_BUSY;
          cnt_q   <= CNT_W'(BUSY_CYC - 1);
          cmd_q   <= 1'b1;
        end
        ST_BUSY: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == ST_PEND);
  assign busy_o = (state_q == ST_BUSY);
  assign cmd_o  = cmd_q;
  assign row_o  = row_q;

  // checker: busy run length
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + (CNT_W+1)'(1);
    else             run_q <= '0;
  end

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == (CNT_W+1)'(BUSY_CYC)));

  assert_issue_after_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_o && sched_idle_i));

  assert_cmd_first_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> (busy_o && $rose(busy_o)));

  assert_hold_request_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !sched_idle_i) |=> (req_o && $stable(row_o)));

  assert_tick_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (!req_o && !busy_o));
endmodule

// File: rtl/rr_refresh_ctrl.sv
module rr_refresh_ctrl
  import rr_refresh_pkg::*;
#(
  parameter int unsigned ROWS      = 64,
  parameter int unsigned ROW_W     = $clog2(ROWS),
  parameter int unsigned FILT_BITS = 32,
  parameter int unsigned NUM_HASH  = 2,
  parameter int unsigned BUSY_CYC  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             prof_we_i,
  input  logic             prof_bin_i,
  input  logic [ROW_W-1:0] prof_row_i,
  input  logic             sched_idle_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ref_cmd_o,
  output logic             busy_o
);
  logic [ROW_W-1:0]    cur_row;
  logic [PER_W-1:0]    cur_per;
  logic [NUM_FILT-1:0] hit;
  rf_bin_e             bin;
  logic                need;

  rr_row_sequencer #(.ROWS(ROWS), .ROW_W(ROW_W)) i_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .row_o (cur_row),
    .per_o (cur_per)
  );

  for (genvar g = 0; g < int'(NUM_FILT); g++) begin : g_filt
    rr_bloom_filter #(.ROW_W(ROW_W), .FILT_BITS(FILT_BITS), .NUM_HASH(NUM_HASH)) i_bf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .we_i    (prof_we_i && (prof_bin_i == 1'(g))),
      .wr_row_i(prof_row_i),
      .rd_row_i(cur_row),
      .hit_o   (hit[g])
    );
  end

  // lowest-index filter wins
  always_comb begin
    bin = BIN_STRONG;
    for (int f = int'(NUM_FILT) - 1; f >= 0; f--)
      if (hit[f]) bin = rf_bin_e'(2'(f));
  end

  assign need = due_f(bin, cur_per);

  rr_refresh_fsm #(.ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .need_i      (need),
    .row_i       (cur_row),
    .sched_idle_i(sched_idle_i),
    .req_o       (ref_req_o),
    .row_o       (ref_row_o),
    .cmd_o       (ref_cmd_o),
    .busy_o      (busy_o)
  );

  assert_weak_always_due_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit[0]) |=> ref_req_o);
endmodule

// File: tb/test_rr_refresh_ctrl.sv
`timescale 1ns/1ps
module test_rr_refresh_ctrl;
  localparam int ROWS = 40;
  localparam int RW   = 6;
  localparam int M    = 32;
  localparam int K    = 2;
  localparam int B    = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, clr = 1'b0, we = 1'b0, pbin = 1'b0, idle = 1'b0;
  logic [RW-1:0] prow = '0;
  logic ref_req, ref_cmd, busy;
  logic [RW-1:0] ref_row;

  always #2 clk = ~clk;

  rr_refresh_ctrl #(.ROWS(ROWS), .FILT_BITS(M), .NUM_HASH(K), .BUSY_CYC(B)) i_rr_refresh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clear_i(clr), .prof_we_i(we),
    .prof_bin_i(pbin), .prof_row_i(prow), .sched_idle_i(idle),
    .ref_req_o(ref_req), .ref_row_o(ref_row), .ref_cmd_o(ref_cmd), .busy_o(busy)
  );

  int checks = 0, fails = 0;
  int exp_row = 0, exp_per = 0;
  bit filt [2][M];
  bit finished = 0;
  string phase = "";

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int hsh(input int r, input int k);
    int v;
    v = ((r << k) | (r >> (RW - k))) & 63;
    return (v & 31) ^ (v >> 5) ^ k;
  endfunction

  function automatic bit member(input int f, input int r);
    for (int k = 0; k < K; k++) if (!filt[f][hsh(r, k)]) return 0;
    return 1;
  endfunction

  function automatic int bin_of(input int r);
    if (member(0, r)) return 0;
    if (member(1, r)) return 1;
    return 2;
  endfunction

  function automatic bit due(input int b, input int p);
    if (b == 0) return 1;
    if (b == 1) return (p % 2) == 0;
    return p == 0;
  endfunction

  task automatic profile(input int f, input int r);
    @(negedge clk);
    we = 1'b1; pbin = f[0]; prow = RW'(r);
    @(negedge clk);
    we = 1'b0;
    for (int k = 0; k < K; k++) filt[f][hsh(r, k)] = 1;
  endtask

  task automatic do_tick(input int wait_cyc);
    int b;
    bit d;
    b = bin_of(exp_row);
    d = due(b, exp_per);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (d) begin
      chk(ref_req == 1'b1, {"R3 R4 R5 due request ", phase}, ref_req, 1);
      chk(ref_row == RW'(exp_row), "R2 R5 request row", ref_row, exp_row);
      for (int w = 0; w < wait_cyc; w++) begin
        @(negedge clk);
        chk(ref_req == 1'b1 && busy == 1'b0, "R6 request held", ref_req, 1);
        chk(ref_row == RW'(exp_row), "R6 row held", ref_row, exp_row);
      end
      idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
      chk(busy == 1'b1 && ref_cmd == 1'b1 && ref_req == 1'b0, "R7 issue cycle",
          {busy, ref_cmd, ref_req}, 3'b110);
      for (int j = 1; j < B; j++) begin
        @(negedge clk);
        chk(busy == 1'b1 && ref_cmd == 1'b0, "R7 busy hold", {busy, ref_cmd}, 2'b10);
      end
      @(negedge clk);
      chk(busy == 1'b0 && ref_req == 1'b0, "R7 busy end", busy, 0);
    end else begin
      chk(ref_req == 1'b0 && busy == 1'b0, {"R3 R4 R9 not due ", phase}, ref_req, 0);
    end
    if (exp_row == ROWS - 1) begin
      exp_row = 0;
      exp_per = (exp_per + 1) % 4;
    end else exp_row++;
  endtask

  task automatic sweep(input int n);
    for (int t = 0; t < n; t++) do_tick((exp_row % 5 == 0) ? 2 : 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ref_req == 1'b0, "R1 reset req", ref_req, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(ref_cmd == 1'b0, "R1 reset cmd", ref_cmd, 0);
    chk(ref_row == '0, "R1 reset row", ref_row, 0);

    profile(0, 3); profile(0, 17); profile(0, 33);
    profile(1, 5); profile(1, 17); profile(1, 22); profile(1, 39);
    phase = "profiled";
    sweep(5 * ROWS);

    @(negedge clk);
    clr = 1'b1; we = 1'b1; pbin = 1'b0; prow = RW'(3);
    @(negedge clk);
    clr = 1'b0; we = 1'b0;
    for (int f = 0; f < 2; f++) for (int i = 0; i < M; i++) filt[f][i] = 0;
    phase = "R8 after clear";
    sweep(4 * ROWS);

    profile(1, 9);
    phase = "reprofiled";
    sweep(2 * ROWS);

    finished = 1;
    report();
    $finish;
  end
endmodule